// File: doc/BRIEF.md
# Rotating tiled view address generator

This block turns a pixel coordinate inside a two-dimensional tiled container into the bus address through which that pixel is reached in a rotated or mirrored view. The caller picks one of four pixel formats and one of eight view orientations, then presents an X and a Y coordinate. The block returns a 32-bit tiled-space address, the line stride that goes with the chosen format and orientation, and a flag that marks a coordinate lying outside the usable range of the container for that format.

Each format leaves a fixed number of low coordinate bits unused. The three narrow pixel formats drop 0 or 1 bit per axis. Page mode drops a whole slot's worth of bits per axis. The usable X and Y widths are the container widths less those shifts. Mirroring flips a coordinate by XOR with its mask. The 90 and 270 degree views swap the roles of X and Y. The resulting linear offset is aligned by the sum of both format shifts. Format and orientation codes are then placed in the top address bits.

Container and slot sizes are parameters. A parameter selects between a purely combinational path and a one-cycle registered path, in which an output valid follows the input valid.

Top module: `tiled_view_addr`

## Requirements
- R1: Address bits [28:27] carry the format code: 0 for 8-bit pixels, 1 for 16-bit, 2 for 32-bit, 3 for page mode.
- R2: Address bits [31:29] carry the orientation code. Within the code, bit 0 mirrors Y, bit 1 mirrors X and bit 2 swaps X and Y. Codes 0, 3, 6 and 5 are the 0, 180, 90 and 270 degree views. Codes 2, 1, 7 and 4 are the same views with mirroring.
- R3: The usable X width is CONT_W_BITS minus the format's X shift, and the usable Y width is CONT_H_BITS minus its Y shift. A coordinate above its all-ones mask gives address 0 and raises coord_bad. coord_bad is low otherwise.
- R4: With the X-mirror bit set, X is XORed with its full mask before use. With the Y-mirror bit set, Y is XORed with its mask.
- R5: Without swap, the linear offset is (y << x_width) + x. With swap, it is (x << y_width) + y.
- R6: The per-format (X, Y) shifts are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (SLOT_W_BITS, SLOT_H_BITS) for page mode. The linear offset is shifted left by X shift plus Y shift into address bits [26:0].
- R7: stride is 1 << (CONT_H_BITS + X shift) when swapped, else 1 << (CONT_W_BITS + Y shift). It does not depend on the coordinate.
- R8: In the registered variant, results appear one clock after the inputs are presented, and out_valid equals in_valid of the previous cycle.
- R9: In the registered variant, a cycle with in_valid low leaves addr, stride and coord_bad unchanged.
- R10: While rst_n is low, the registered outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request presented this cycle |
| fmt_sel | input | 2 | Pixel format code |
| orient_sel | input | 3 | View orientation code |
| coord_x | input | CONT_W_BITS+1 | Pixel X coordinate |
| coord_y | input | CONT_H_BITS+1 | Pixel Y coordinate |
| out_valid | output | 1 | Result valid |
| addr | output | 32 | Tiled-space address |
| stride | output | 32 | Line stride in bytes for the view |
| coord_bad | output | 1 | Coordinate outside usable range |

## Verification
The assertions take for granted that fmt_sel and orient_sel are free of unknown bits whenever in_valid is high. The field assertions compare against inputs captured one cycle earlier, so they assume the registered variant. The stimulus always drives defined values on all inputs, even while in_valid is low. It sweeps every format and orientation against every X and Y value of a small container, including values one bit wider than any usable range, so each mask boundary is crossed on both sides.

// File: rtl/tvg_pkg.sv
package tvg_pkg;

   localparam int ADDR_W   = 32;
   localparam int OFF_W    = 27;
   localparam int NUM_FMT  = 4;

   typedef enum logic [1:0] {
      PIX8    = 2'd0,
      PIX16   = 2'd1,
      PIX32   = 2'd2,
      PIXPAGE = 2'd3
   } pix_fmt_e;

   // bit 2: swap axes, bit 1: mirror X, bit 0: mirror Y
   typedef struct packed {
      logic swap;
      logic inv_x;
      logic inv_y;
   } view_t;

   function automatic int fmt_shift_x(int f, int slot_w_bits);
      case (f)
         0, 1:    return 0;
         2:       return 1;
         default: return slot_w_bits;
      endcase
   endfunction

   function automatic int fmt_shift_y(int f, int slot_h_bits);
      case (f)
         0:       return 0;
         1, 2:    return 1;
         default: return slot_h_bits;
      endcase
   endfunction

endpackage

// File: rtl/tvg_lane.sv
module tvg_lane
   import tvg_pkg::*;
#(
   parameter int CW = 14,
   parameter int CH = 13,
   parameter int XS = 0,
   parameter int YS = 0
) (
   input  logic [CW:0]       coord_x,
   input  logic [CH:0]       coord_y,
   input  view_t             view,
   output logic              in_range,
   output logic [OFF_W-1:0]  offset,
   output logic [ADDR_W-1:0] stride
);

   localparam int XB    = CW - XS;
   localparam int YB    = CH - YS;
   localparam int AL    = XS + YS;
   localparam int LIN_W = XB + YB;
   localparam int SH_SW = CH + XS;
   localparam int SH_NS = CW + YS;
   localparam logic [ADDR_W-1:0] STRIDE_SWAP = ADDR_W'(1) << SH_SW;
   localparam logic [ADDR_W-1:0] STRIDE_STR  = ADDR_W'(1) << SH_NS;

   generate
      if (XB < 1 || YB < 1) begin : g_bad_width
         $error("tvg_lane: usable coordinate width must be at least one bit");
      end
      if (LIN_W + AL > OFF_W) begin : g_bad_off
         $error("tvg_lane: aligned offset does not fit the offset field");
      end
      if (SH_SW >= ADDR_W || SH_NS >= ADDR_W) begin : g_bad_stride
         $error("tvg_lane: stride exponent exceeds address width");
      end
   endgenerate

   logic [XB-1:0]      xm;
   logic [YB-1:0]      ym;
   logic [LIN_W-1:0]   lin;
   logic [CW+CH-1:0]   aligned;

   assign in_range = ((coord_x >> XB) == '0) && ((coord_y >> YB) == '0);

   assign xm  = coord_x[XB-1:0] ^ {XB{view.inv_x}};
   assign ym  = coord_y[YB-1:0] ^ {YB{view.inv_y}};
   assign lin = view.swap ? {xm, ym} : {ym, xm};

   generate
      if (AL == 0) begin : g_noalign
         assign aligned = lin;
      end else begin : g_align
         assign aligned = {lin, {AL{1'b0}}};
      end
   endgenerate

   assign offset = OFF_W'(aligned);
   assign stride = view.swap ? STRIDE_SWAP : STRIDE_STR;

endmodule

// File: rtl/tvg_select.sv
module tvg_select
   import tvg_pkg::*;
(
   input  pix_fmt_e                      fmt,
   input  view_t                         view,
   input  logic [NUM_FMT-1:0]            lane_rng,
   input  logic [NUM_FMT-1:0][OFF_W-1:0] lane_off,
   input  logic [NUM_FMT-1:0][ADDR_W-1:0] lane_str,
   output logic [ADDR_W-1:0]             addr_d,
   output logic [ADDR_W-1:0]             stride_d,
   output logic                          bad_d
);

   logic ok;

   assign ok       = lane_rng[fmt];
   assign bad_d    = ~ok;
   assign stride_d = lane_str[fmt];
   assign addr_d   = ok ? {view, fmt, lane_off[fmt]} : '0;

endmodule

// File: rtl/tvg_outstage.sv
module tvg_outstage
   import tvg_pkg::*;
#(
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic [ADDR_W-1:0] stride_d,
   input  logic              bad_d,
   output logic              out_valid,
   output logic [ADDR_W-1:0] addr_q,
   output logic [ADDR_W-1:0] stride_q,
   output logic              bad_q
);

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               addr_q    <= '0;
               stride_q  <= '0;
               bad_q     <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  addr_q   <= addr_d;
                  stride_q <= stride_d;
                  bad_q    <= bad_d;
               end
            end
         end

         // R8
         vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         // R8
         vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
         // R9
         idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(addr_q) && $stable(stride_q) && $stable(bad_q)));
      end else begin : g_comb
         assign out_valid = in_valid;
         assign addr_q    = addr_d;
         assign stride_q  = stride_d;
         assign bad_q     = bad_d;
      end
   endgenerate

endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr
   import tvg_pkg::*;
#(
   parameter int CONT_W_BITS = 14,
   parameter int CONT_H_BITS = 13,
   parameter int SLOT_W_BITS = 6,
   parameter int SLOT_H_BITS = 6,
   parameter bit REGISTERED  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [1:0]             fmt_sel,
   input  logic [2:0]             orient_sel,
   input  logic [CONT_W_BITS:0]   coord_x,
   input  logic [CONT_H_BITS:0]   coord_y,
   output logic                   out_valid,
   output logic [31:0]            addr,
   output logic [31:0]            stride,
   output logic                   coord_bad
);

   generate
      if (CONT_W_BITS + CONT_H_BITS > OFF_W) begin : g_bad_cont
         $error("tiled_view_addr: container too large for the offset field");
      end
      if (SLOT_W_BITS >= CONT_W_BITS || SLOT_H_BITS >= CONT_H_BITS) begin : g_bad_slot
         $error("tiled_view_addr: slot must be smaller than the container");
      end
   endgenerate

   view_t                           view;
   pix_fmt_e                        fmt;
   logic [NUM_FMT-1:0]              lane_rng;
   logic [NUM_FMT-1:0][OFF_W-1:0]   lane_off;
   logic [NUM_FMT-1:0][ADDR_W-1:0]  lane_str;
   logic [ADDR_W-1:0]               addr_d;
   logic [ADDR_W-1:0]               stride_d;
   logic                            bad_d;

   assign view = view_t'(orient_sel);
   assign fmt  = pix_fmt_e'(fmt_sel);

   for (genvar f = 0; f < NUM_FMT; f++) begin : g_lane
      tvg_lane #(
         .CW (CONT_W_BITS),
         .CH (CONT_H_BITS),
         .XS (fmt_shift_x(f, SLOT_W_BITS)),
         .YS (fmt_shift_y(f, SLOT_H_BITS))
      ) u_lane (
         .coord_x  (coord_x),
         .coord_y  (coord_y),
         .view     (view),
         .in_range (lane_rng[f]),
         .offset   (lane_off[f]),
         .stride   (lane_str[f])
      );
   end

   tvg_select u_sel (
      .fmt      (fmt),
      .view     (view),
      .lane_rng (lane_rng),
      .lane_off (lane_off),
      .lane_str (lane_str),
      .addr_d   (addr_d),
      .stride_d (stride_d),
      .bad_d    (bad_d)
   );

   tvg_outstage #(.REGISTERED(REGISTERED)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .addr_d    (addr_d),
      .stride_d  (stride_d),
      .bad_d     (bad_d),
      .out_valid (out_valid),
      .addr_q    (addr),
      .stride_q  (stride),
      .bad_q     (coord_bad)
   );

   generate
      if (REGISTERED) begin : g_chk
         // R3
         bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && coord_bad) |-> (addr == '0));
         // R1
         fmt_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (coord_bad || (addr[28:27] == $past(fmt_sel))));
         // R2
         view_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (coord_bad || (addr[31:29] == $past(orient_sel))));
         // R7
         stride_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ($countones(stride) == 1));
      end
   endgenerate

endmodule

// File: tb/tiled_view_addr_test.sv
module tiled_view_addr_test;

   localparam int CW = 5;
   localparam int CH = 4;
   localparam int SW = 2;
   localparam int SH = 2;
   localparam int XN = 1 << (CW + 1);
   localparam int YN = 1 << (CH + 1);

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n;
   logic          in_valid;
   logic [1:0]    fmt_sel;
   logic [2:0]    orient_sel;
   logic [CW:0]   coord_x;
   logic [CH:0]   coord_y;
   logic          out_valid;
   logic [31:0]   addr;
   logic [31:0]   stride;
   logic          coord_bad;

   tiled_view_addr #(
      .CONT_W_BITS (CW),
      .CONT_H_BITS (CH),
      .SLOT_W_BITS (SW),
      .SLOT_H_BITS (SH),
      .REGISTERED  (1'b1)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .fmt_sel    (fmt_sel),
      .orient_sel (orient_sel),
      .coord_x    (coord_x),
      .coord_y    (coord_y),
      .out_valid  (out_valid),
      .addr       (addr),
      .stride     (stride),
      .coord_bad  (coord_bad)
   );

   int n_vec  = 0;
   int n_miss = 0;
   bit done   = 1'b0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_miss++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic void model(input int f, input int o, input int x, input int y,
                                 output logic [31:0] a, output logic [31:0] s,
                                 output logic b);
      int xs, ys, xb, yb, xmask, ymask, xv, yv, lin;
      logic [31:0] ov, fv;
      xs = (f == 3) ? SW : ((f == 2) ? 1 : 0);
      ys = (f == 3) ? SH : ((f == 0) ? 0 : 1);
      xb = CW - xs;
      yb = CH - ys;
      xmask = (1 << xb) - 1;
      ymask = (1 << yb) - 1;
      s = ((o & 4) != 0) ? (32'd1 << (CH + xs)) : (32'd1 << (CW + ys));
      if (x > xmask || y > ymask) begin
         a = 32'd0;
         b = 1'b1;
      end else begin
         xv = ((o & 2) != 0) ? (x ^ xmask) : x;
         yv = ((o & 1) != 0) ? (y ^ ymask) : y;
         lin = ((o & 4) != 0) ? ((xv << yb) + yv) : ((yv << xb) + xv);
         ov = 32'(o);
         fv = 32'(f);
         a = (ov << 29) | (fv << 27) | 32'(lin << (xs + ys));
         b = 1'b0;
      end
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_miss++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
         $finish;
      end
   end

   initial begin
      logic [31:0] ea, es;
      logic        eb;
      string       tag;
      rst_n      = 1'b0;
      in_valid   = 1'b1;
      fmt_sel    = 2'd2;
      orient_sel = 3'd5;
      coord_x    = 3;
      coord_y    = 2;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 out_valid", 32'(out_valid), 32'd0);
      chk("R10 addr", addr, 32'd0);
      chk("R10 stride", stride, 32'd0);
      chk("R10 coord_bad", 32'(coord_bad), 32'd0);
      rst_n    = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      chk("R8 idle out_valid", 32'(out_valid), 32'd0);

      for (int f = 0; f < 4; f++) begin
         for (int o = 0; o < 8; o++) begin
            for (int x = 0; x < XN; x++) begin
               for (int y = 0; y < YN; y++) begin
                  fmt_sel    = 2'(f);
                  orient_sel = 3'(o);
                  coord_x    = (CW + 1)'(x);
                  coord_y    = (CH + 1)'(y);
                  in_valid   = 1'b1;
                  @(negedge clk);
                  model(f, o, x, y, ea, es, eb);
                  if (eb) tag = "R3 addr";
                  else if ((o & 3) != 0) tag = "R4 addr";
                  else if ((o & 4) != 0) tag = "R5 addr";
                  else tag = "R6 addr";
                  chk(tag, addr, ea);
                  chk("R3 coord_bad", 32'(coord_bad), 32'(eb));
                  chk("R7 stride", stride, es);
                  chk("R8 out_valid", 32'(out_valid), 32'd1);
                  if (!eb) begin
                     chk("R1 fmt field", 32'(addr[28:27]), 32'(f));
                     chk("R2 view field", 32'(addr[31:29]), 32'(o));
                  end
                  if (((x * YN + y) % 97) == 5) begin
                     // R9: idle cycle with changed inputs leaves results alone
                     in_valid   = 1'b0;
                     coord_x    = coord_x ^ 1;
                     orient_sel = orient_sel ^ 3'd4;
                     fmt_sel    = fmt_sel ^ 2'd1;
                     @(negedge clk);
                     chk("R9 addr hold", addr, ea);
                     chk("R9 stride hold", stride, es);
                     chk("R9 coord_bad hold", 32'(coord_bad), 32'(eb));
                     chk("R8 out_valid low", 32'(out_valid), 32'd0);
                  end
               end
            end
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

endmodule